// File: doc/BRIEF.md
# Local countdown timer with prescaler

This block is the countdown timer that sits next to one processor's interrupt controller. A free-running prescaler divides the core clock by a programmable power of two. Its ticks step a down-counter that starts from a software-written initial value. In one-shot mode the counter stops at zero and raises a single expiry event. In periodic mode it reloads and raises an event on every period boundary.

Three write strobes share one data bus. They load the initial count, the divide setting and the timer control word. The control word carries an 8-bit vector, a mask flag and a periodic flag. The running count is always visible on an output for readback. Each expiry is a one-cycle event with the vector valid in the same cycle, and it is always edge-triggered. Address decoding and interrupt prioritisation belong to the neighbouring logic that receives the event.

Top module: `lct_timer`

## Requirements
- R1: A divide write keeps data bits 3, 1 and 0. A 3-bit code is formed with bit 3 as its most significant bit and bits 1:0 below it. The prescaler shift is (code + 1) mod 8 and the tick period is 2^shift clock cycles, so data 0xB divides by 1, 0x0 and 0x4 by 2, 0x3 by 16 and 0x8 by 32.
- R2: A count write loads the counter, so `cur_count` shows the written value one cycle later. It also restarts the prescaler phase: the first decrement happens exactly 2^shift cycles after the loading edge. A count write issued mid-count abandons the old count.
- R3: In one-shot mode, j clock edges after the loading edge `cur_count` equals max(N - floor(j / P), 0), where N is the initial count and P is the tick period.
- R4: In one-shot mode with N > 0 and the timer unmasked, exactly one expiry occurs, with `expire_o` high after edge j = (N + 1) * P. No further expiry follows until the next count write.
- R5: In periodic mode `cur_count` equals N - (floor(j / P) mod (N + 1)). An expiry occurs after every edge j that is a positive multiple of (N + 1) * P.
- R6: Control word fields: bit 17 selects periodic mode (1) or one-shot (0), bit 16 masks the timer (1 = masked), and bits 7:0 are the vector. The vector held when an expiry falls due appears on `expire_vec_o` in the same cycle as `expire_o`.
- R7: While masked the timer produces no expiry, but the counter keeps counting and reloading exactly as when unmasked.
- R8: A control word write re-evaluates the schedule. A one-shot expiry that fell due while masked is used up, so unmasking afterwards yields no event. Unmasking before the counter reaches zero keeps the pending one-shot expiry at its normal time.
- R9: After reset the control word is masked, one-shot, with vector 0. The divide setting is code 0 (divide by 2), the count reads 0 and `expire_o` is low. A count loaded before any control write counts down but raises no event.
- R10: A one-shot initial count of zero produces no expiry, and `cur_count` stays at zero.
- R11: With a period longer than one clock cycle, `expire_o` is a single-cycle pulse: it is low in the cycles just before and just after each expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_wr | input | 1 | Strobe: load initial count from `wr_data` |
| div_wr | input | 1 | Strobe: load divide setting from `wr_data` |
| ctrl_wr | input | 1 | Strobe: load control word from `wr_data` |
| wr_data | input | DATA_W | Shared write data |
| cur_count | output | CNT_W | Current counter value |
| expire_o | output | 1 | One-cycle expiry event |
| expire_vec_o | output | 8 | Vector delivered with the event |

## Verification
The bench builds the timer with a 16-bit counter and a 32-bit data bus. Small initial counts let a complete one-shot run, and three full periodic periods, fit into windows of a few hundred cycles. The bench uses divide settings from divide-by-1 to divide-by-16. This reaches the scrambled code bits, including the ignored bit 2 and the wrap of code 7 to a shift of zero. The short windows also let the bench compare every cycle of the count trace against its own formula, not just the cycle of expiry.

// File: rtl/lct_pkg.sv
package lct_pkg;
  // control word field positions (neighbours decode these)
  localparam int unsigned CTRL_PER_BIT = 17;
  localparam int unsigned CTRL_MSK_BIT = 16;
  localparam int unsigned VEC_W        = 8;
  localparam int unsigned CODE_W       = 3;
  // largest shift is 2^CODE_W - 1, so the phase counter needs that many bits
  localparam int unsigned PHASE_W      = (1 << CODE_W) - 1;

  // scrambled divide code -> prescaler shift, wrapping modulo 8
  function automatic logic [CODE_W-1:0] div_shift(input logic [CODE_W-1:0] code);
    return code + 1'b1;
  endfunction

  // low-ones mask that marks the last phase of a prescaler period
  function automatic logic [PHASE_W-1:0] phase_mask(input logic [CODE_W-1:0] sh);
    logic [PHASE_W:0] one_hot;
    one_hot = {{PHASE_W{1'b0}}, 1'b1} << sh;
    return PHASE_W'(one_hot - 1'b1);
  endfunction
endpackage

// File: rtl/lct_prescale.sv
module lct_prescale
  import lct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [CODE_W-1:0] shift,
  output logic              tick
);
  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] last_phase;

  assign last_phase = phase_mask(shift);
  assign tick       = (phase_q & last_phase) == last_phase;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) phase_q <= '0;
    else                   phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/lct_downcount.sv
module lct_downcount #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             periodic,
  input  logic             masked,
  input  logic             reeval,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] init_val,
  output logic             period_edge,
  output logic             armed,
  output logic             fire
);
  logic [CNT_W-1:0] count_q, count_d, init_q;
  logic             armed_q, armed_d, at_zero;

  assign at_zero     = (count_q == '0);
  // a boundary is where the count would step below zero
  assign period_edge = !load && tick && at_zero && (periodic || armed_q);
  assign fire        = period_edge && !masked;

  always_comb begin
    count_d = count_q;
    if (load)                count_d = load_val;
    else if (tick) begin
      if (!at_zero)          count_d = count_q - 1'b1;
      else if (periodic)     count_d = init_q;
    end
  end

  always_comb begin
    armed_d = armed_q;
    if (load)                          armed_d = (load_val != '0);
    else if (period_edge && !periodic) armed_d = 1'b0;
    else if (reeval)                   armed_d = (count_d != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      init_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      count_q <= count_d;
      armed_q <= armed_d;
      if (load) init_q <= load_val;
    end
  end

  assign count    = count_q;
  assign init_val = init_q;
  assign armed    = armed_q;
endmodule

// File: rtl/lct_timer.sv
module lct_timer
  import lct_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_wr,
  input  logic              div_wr,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  cur_count,
  output logic              expire_o,
  output logic [VEC_W-1:0]  expire_vec_o
);
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] shift;
  logic [VEC_W-1:0]  vec_q;
  logic              per_q, msk_q;
  logic              tick, fire, period_edge, armed;
  logic [CNT_W-1:0]  init_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      vec_q  <= '0;
      per_q  <= 1'b0;
      msk_q  <= 1'b1;
    end else begin
      if (div_wr)  code_q <= {wr_data[3], wr_data[1:0]};
      if (ctrl_wr) begin
        vec_q <= wr_data[VEC_W-1:0];
        per_q <= wr_data[CTRL_PER_BIT];
        msk_q <= wr_data[CTRL_MSK_BIT];
      end
    end
  end

  assign shift = div_shift(code_q);

  lct_prescale u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (count_wr),
    .shift   (shift),
    .tick    (tick)
  );

  lct_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (count_wr),
    .load_val    (wr_data[CNT_W-1:0]),
    .tick        (tick),
    .periodic    (per_q),
    .masked      (msk_q),
    .reeval      (ctrl_wr),
    .count       (cur_count),
    .init_val    (init_val),
    .period_edge (period_edge),
    .armed       (armed),
    .fire        (fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      expire_o     <= 1'b0;
      expire_vec_o <= '0;
    end else begin
      expire_o <= fire;
      if (fire) expire_vec_o <= vec_q;
    end
  end
endmodule

// File: rtl/lct_timer_chk.sv
module lct_timer_chk #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              count_wr,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  cur_count,
  input logic [CNT_W-1:0]  init_val,
  input logic              expire_o,
  input logic [7:0]        expire_vec_o,
  input logic [7:0]        vec_now,
  input logic              tick,
  input logic              fire,
  input logic              msk_now,
  input logic              per_now,
  input logic              armed
);
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count_wr |=> cur_count == $past(wr_data[CNT_W-1:0]));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_wr && !tick) |=> $stable(cur_count));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !count_wr |=> (cur_count == $past(cur_count))
               || (cur_count == $past(cur_count) - 1'b1)
               || ($past(cur_count) == '0 && cur_count == init_val));

  p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msk_now |-> !fire);

  p_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> expire_o && expire_vec_o == $past(vec_now));

  p_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !expire_o);

  p_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !per_now) |=> !armed);

  p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (count_wr && wr_data[CNT_W-1:0] == '0) |=> !armed);
endmodule

bind lct_timer lct_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .count_wr     (count_wr),
  .wr_data      (wr_data),
  .cur_count    (cur_count),
  .init_val     (init_val),
  .expire_o     (expire_o),
  .expire_vec_o (expire_vec_o),
  .vec_now      (vec_q),
  .tick         (tick),
  .fire         (fire),
  .msk_now      (msk_q),
  .per_now      (per_q),
  .armed        (armed)
);

// File: tb/lct_timer_bench.sv
module lct_timer_bench;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              count_wr = 1'b0, div_wr = 1'b0, ctrl_wr = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [CNT_W-1:0]  cur_count;
  logic              expire_o;
  logic [7:0]        expire_vec_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lct_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_lct_timer (
    .clk(clk), .rst_n(rst_n), .count_wr(count_wr), .div_wr(div_wr),
    .ctrl_wr(ctrl_wr), .wr_data(wr_data), .cur_count(cur_count),
    .expire_o(expire_o), .expire_vec_o(expire_vec_o)
  );

  function automatic int period_of(input int cfg);
    int code;
    code = (((cfg >> 3) & 1) << 2) | (cfg & 3);
    return 1 << ((code + 1) % 8);
  endfunction

  function automatic int ctrl_word(input bit per, input bit msk, input int vec);
    return (int'(per) << 17) | (int'(msk) << 16) | (vec & 255);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // 0: count, 1: divide, 2: control. Returns just after the capturing edge.
  task automatic wr(input int kind, input int data);
    @(negedge clk);
    wr_data  = data;
    count_wr = (kind == 0);
    div_wr   = (kind == 1);
    ctrl_wr  = (kind == 2);
    @(posedge clk);
    #1;
    count_wr = 0; div_wr = 0; ctrl_wr = 0;
  endtask

  // j = edges since the loading edge; observes from j0 to len
  task automatic run_window(input int n, input int p, input bit per, input bit mute,
                            input int vec, input int j0, input int len, input string req);
    int ticks, ec, plen, exp_n, got_n, jc, je;
    bit ee, bad_c, bad_e;
    longint ac, xc, ae, xe;
    plen = (n + 1) * p;
    exp_n = 0; got_n = 0; bad_c = 0; bad_e = 0; jc = 0; je = 0;
    ac = 0; xc = 0; ae = 0; xe = 0;
    for (int j = j0; j <= len; j++) begin
      @(negedge clk);
      ticks = j / p;
      if (per) ec = n - (ticks % (n + 1));
      else     ec = (ticks >= n) ? 0 : n - ticks;
      ee = !mute && (per ? (j > 0 && j % plen == 0) : (n != 0 && j == plen));
      if (ee) exp_n++;
      if (expire_o) got_n++;
      if (!bad_c && int'(cur_count) != ec) begin
        bad_c = 1; jc = j; ac = cur_count; xc = ec;
      end
      if (!bad_e && (expire_o !== ee || (ee && int'(expire_vec_o) != vec))) begin
        bad_e = 1; je = j; ae = {expire_o, expire_vec_o}; xe = {ee, 8'(vec)};
      end
    end
    check(!bad_c, req, $sformatf("count trace first mismatch at j=%0d", jc), ac, xc);
    check(!bad_e, req, $sformatf("R11 event/vector {evt,vec} at j=%0d", je), ae, xe);
    check(got_n == exp_n, req, "event total", got_n, exp_n);
  endtask

  task automatic t_reset();
    check(cur_count == 0, "R9", "count after reset", cur_count, 0);
    check(expire_o == 0, "R9", "event after reset", expire_o, 0);
    wr(0, 2);  // reset divide (by 2), reset control (masked)
    run_window(2, 2, 0, 1, 0, 0, 16, "R9 R1 default divide and mask");
  endtask

  task automatic t_oneshot(input int cfg, input int n, input int vec, input string req);
    int p;
    p = period_of(cfg);
    wr(1, cfg);
    wr(2, ctrl_word(0, 0, vec));
    wr(0, n);
    run_window(n, p, 0, 0, vec, 0, (n + 1) * p + 3 * p + 4, req);
  endtask

  task automatic t_periodic(input int cfg, input int n, input int vec, input string req);
    int p;
    p = period_of(cfg);
    wr(1, cfg);
    wr(2, ctrl_word(1, 0, vec));
    wr(0, n);
    run_window(n, p, 1, 0, vec, 0, 3 * (n + 1) * p + 1, req);
  endtask

  task automatic t_masked_periodic();
    wr(1, 'hB);
    wr(2, ctrl_word(1, 1, 'h33));
    wr(0, 2);
    run_window(2, 1, 1, 1, 'h33, 0, 15, "R7 masked periodic keeps counting");
  endtask

  task automatic t_reeval_spent();
    int seen;
    wr(1, 'hB);
    wr(2, ctrl_word(0, 1, 'h44));
    wr(0, 2);
    repeat (8) @(negedge clk);
    wr(2, ctrl_word(0, 0, 'h44));
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (expire_o) seen++;
    end
    check(seen == 0, "R8", "events after late unmask", seen, 0);
    check(cur_count == 0, "R8", "count after late unmask", cur_count, 0);
  endtask

  task automatic t_reeval_live();
    wr(1, 'hB);
    wr(2, ctrl_word(0, 1, 'h55));
    wr(0, 10);
    wr(2, ctrl_word(0, 0, 'h55));  // captured at j=1
    run_window(10, 1, 0, 0, 'h55, 1, 20, "R8 early unmask keeps expiry");
  endtask

  task automatic t_reload();
    wr(1, 'h0);
    wr(2, ctrl_word(0, 0, 'h66));
    wr(0, 20);
    repeat (7) @(negedge clk);
    wr(0, 3);
    run_window(3, 2, 0, 0, 'h66, 0, 16, "R2 reload restarts count and phase");
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_oneshot('hB, 5, 'hA1, "R1 R3 R4 divide-by-1 one-shot");
    t_oneshot('h0, 4, 'hA2, "R1 R3 R4 divide-by-2 one-shot");
    t_oneshot('h3, 2, 'hA3, "R1 R3 R4 divide-by-16 one-shot");
    t_oneshot('h4, 3, 'hA4, "R1 bit2 ignored one-shot");
    t_oneshot('hB, 0, 'hA5, "R10 zero count one-shot");
    t_periodic('h0, 3, 'hB1, "R5 R6 periodic divide-by-2");
    t_periodic('hB, 1, 'hB2, "R5 R6 periodic divide-by-1");
    t_masked_periodic();
    t_reeval_spent();
    t_reeval_live();
    t_reload();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule